// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a write-back, write-allocate data cache. Its main array is direct-mapped, and a small fully associative victim buffer sits behind it. Every valid line that leaves the main array lands in the victim buffer. The buffer is searched only when the main array misses. When the buffer holds the requested line, the two lines trade places in a single extra cycle and memory is never touched. This takes back most of the conflict misses that a direct-mapped array suffers when a few hot lines share one set.

The processor side accepts one word-addressed read or write at a time. It answers a main-array hit on the next cycle. The memory side moves whole lines. It has a read request channel, a fill return channel and a writeback channel, and each uses a valid/ready handshake. When both structures miss, the line is fetched from memory. The displaced main line is pushed into the victim buffer slot named by a rotating FIFO pointer. If the entry it overwrites is dirty, that entry is first written back. The line size, the number of main sets and the number of victim entries are parameters.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset no line is valid in either structure. `cpu_ready` is 1, `cpu_rsp_valid` is 0 and no memory channel is active, so the first access to any address fetches from memory.
- R2: A request accepted while `cpu_ready` is 1 that hits the main array raises `cpu_rsp_valid` on the next cycle with the addressed word. It causes no memory traffic.
- R3: A write that hits replaces only the addressed word. Later reads return the written value, and the line is marked dirty.
- R4: When both structures miss, the cache issues one read request whose `mem_rd_addr` is the line address (`cpu_addr >> log2(LINE_WORDS)`). Word k of a line occupies bits [k*WORD_W +: WORD_W] of the fill and writeback data. The response comes the cycle after the fill handshake.
- R5: A valid line displaced from the main array is placed in the victim buffer. A later access to it is served without a memory read.
- R6: A main-array miss that hits the victim buffer swaps the two lines. The response arrives two cycles after acceptance, with no memory traffic, and the displaced main line can then itself be hit in the victim buffer.
- R7: Victim slots are replaced in FIFO order. After VICTIMS further displacements, the oldest victim is gone and needs a memory read.
- R8: A dirty victim entry that is about to be overwritten is written back with its line address and current data before the new fill is requested. A clean or empty entry is never written back.
- R9: A write miss fetches the line, merges the written word and keeps the other words of the fetched line.
- R10: `cpu_ready` is 0 from the cycle after a missing request is accepted until its response. Memory channels are active only while `cpu_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write data |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_rsp_valid | output | 1 | Response pulse for the accepted request |
| cpu_rdata | output | WORD_W | Read word (the written word for writes) |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | ADDR_W-log2(LINE_WORDS) | Line address to fetch |
| mem_fill_valid | input | 1 | Fill line is present |
| mem_fill_ready | output | 1 | Cache is waiting for the fill |
| mem_fill_data | input | WORD_W*LINE_WORDS | Fill line data |
| mem_wb_valid | output | 1 | Writeback request |
| mem_wb_ready | input | 1 | Memory accepts the writeback |
| mem_wb_addr | output | ADDR_W-log2(LINE_WORDS) | Line address written back |
| mem_wb_data | output | WORD_W*LINE_WORDS | Line data written back |

## Verification
The bench drives conflict chains through a single set. They catch a design that loses a line when it is displaced, that fetches from memory on a victim hit, or that fails to return the old main line to the buffer during a swap; each of these shows up as a wrong latency, an unexpected read request or stale data. A run of five conflicting lines pushes a dirty victim out in FIFO order. A design with the wrong replacement order, or one that drops dirty data, sends the wrong writeback address or contents, or writes back a clean line. A write miss and a long random mix over a few hot sets check that merged words and dirty data survive any number of swaps.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
package vc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SWAP  = 3'd1,
      ST_WB    = 3'd2,
      ST_RDREQ = 3'd3,
      ST_FILL  = 3'd4
   } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
`timescale 1ns/1ps
module vc_main_array #(
   parameter int SETS   = 8,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 5,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic              wr_dirty,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line
);
   logic [SETS-1:0]   set_v;
   logic [SETS-1:0]   set_d;
   logic [TAG_W-1:0]  set_tag  [SETS];
   logic [LINE_W-1:0] set_line [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic              v_r;
      logic              d_r;
      logic [TAG_W-1:0]  tag_r;
      logic [LINE_W-1:0] line_r;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            d_r <= 1'b0;
         end else if (sel) begin
            v_r <= wr_valid;
            d_r <= wr_dirty;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_r  <= wr_tag;
            line_r <= wr_line;
         end
      end

      assign set_v[s]    = v_r;
      assign set_d[s]    = d_r;
      assign set_tag[s]  = tag_r;
      assign set_line[s] = line_r;
   end

   assign rd_valid = set_v[rd_idx];
   assign rd_dirty = set_d[rd_idx];
   assign rd_tag   = set_tag[rd_idx];
   assign rd_line  = set_line[rd_idx];
endmodule

// File: rtl/vc_victim_buf.sv
`timescale 1ns/1ps
module vc_victim_buf #(
   parameter int NV     = 4,
   parameter int PTR_W  = 2,
   parameter int LA_W   = 8,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   look_la,
   output logic [NV-1:0]     hit_vec,
   output logic              hit,
   output logic [PTR_W-1:0]  hit_idx,
   output logic              hit_dirty,
   output logic [LINE_W-1:0] hit_line,
   output logic [PTR_W-1:0]  ptr,
   output logic              ptr_valid,
   output logic              ptr_dirty,
   output logic [LA_W-1:0]   ptr_la,
   output logic [LINE_W-1:0] ptr_line,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic              wr_dirty,
   input  logic [LA_W-1:0]   wr_la,
   input  logic [LINE_W-1:0] wr_line,
   input  logic              ptr_adv
);
   logic [NV-1:0]     ent_v;
   logic [NV-1:0]     ent_d;
   logic [LA_W-1:0]   ent_la   [NV];
   logic [LINE_W-1:0] ent_line [NV];
   logic [PTR_W-1:0]  ptr_q;

   for (genvar e = 0; e < NV; e++) begin : g_ent
      logic              v_r;
      logic              d_r;
      logic [LA_W-1:0]   la_r;
      logic [LINE_W-1:0] line_r;
      logic              sel;

      assign sel = wr_en && (wr_idx == PTR_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            d_r <= 1'b0;
         end else if (sel) begin
            v_r <= wr_valid;
            d_r <= wr_dirty;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            la_r   <= wr_la;
            line_r <= wr_line;
         end
      end

      assign ent_v[e]    = v_r;
      assign ent_d[e]    = d_r;
      assign ent_la[e]   = la_r;
      assign ent_line[e] = line_r;
      // one comparator per entry
      assign hit_vec[e]  = v_r && (la_r == look_la);
   end

   always_comb begin
      hit_idx   = '0;
      hit_dirty = 1'b0;
      hit_line  = '0;
      for (int e = 0; e < NV; e++) begin
         if (hit_vec[e]) begin
            hit_idx   = PTR_W'(e);
            hit_dirty = hit_dirty | ent_d[e];
            hit_line  = hit_line | ent_line[e];
         end
      end
   end

   assign hit = |hit_vec;

   if (NV == (1 << PTR_W)) begin : g_ptr_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ptr_q <= '0;
         else if (ptr_adv) ptr_q <= ptr_q + PTR_W'(1);
      end
   end else begin : g_ptr_mod
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ptr_q <= '0;
         else if (ptr_adv) ptr_q <= (ptr_q == PTR_W'(NV - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
   end

   assign ptr       = ptr_q;
   assign ptr_valid = ent_v[ptr_q];
   assign ptr_dirty = ent_d[ptr_q];
   assign ptr_la    = ent_la[ptr_q];
   assign ptr_line  = ent_line[ptr_q];
endmodule

// File: rtl/dm_victim_cache.sv
`timescale 1ns/1ps
module dm_victim_cache #(
   parameter int ADDR_W     = 10,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 8,
   parameter int VICTIMS    = 4
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        cpu_req,
   input  logic                                        cpu_we,
   input  logic [ADDR_W-1:0]                           cpu_addr,
   input  logic [WORD_W-1:0]                           cpu_wdata,
   output logic                                        cpu_ready,
   output logic                                        cpu_rsp_valid,
   output logic [WORD_W-1:0]                           cpu_rdata,
   output logic                                        mem_rd_valid,
   input  logic                                        mem_rd_ready,
   output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]        mem_rd_addr,
   input  logic                                        mem_fill_valid,
   output logic                                        mem_fill_ready,
   input  logic [WORD_W*LINE_WORDS-1:0]                mem_fill_data,
   output logic                                        mem_wb_valid,
   input  logic                                        mem_wb_ready,
   output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]        mem_wb_addr,
   output logic [WORD_W*LINE_WORDS-1:0]                mem_wb_data
);
   import vc_pkg::*;

   localparam int OFF_W  = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int LA_W   = ADDR_W - OFF_W;
   localparam int TAG_W  = LA_W - IDX_W;
   localparam int LINE_W = WORD_W * LINE_WORDS;
   localparam int PTR_W  = (VICTIMS > 1) ? $clog2(VICTIMS) : 1;

   if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen line size and set count");
   end
   if (VICTIMS < 1) begin : g_bad_victims
      $error("VICTIMS must be at least 1");
   end

   vc_state_e           state_q, state_d;
   logic                q_we;
   logic [ADDR_W-1:0]   q_addr;
   logic [WORD_W-1:0]   q_wdata;

   logic [ADDR_W-1:0]   look_addr;
   logic [LA_W-1:0]     look_la;
   logic [IDX_W-1:0]    look_idx;
   logic [TAG_W-1:0]    look_tag;
   logic [OFF_W-1:0]    look_off;
   logic                cur_we;
   logic [WORD_W-1:0]   cur_wdata;

   logic                m_valid, m_dirty;
   logic [TAG_W-1:0]    m_tag;
   logic [LINE_W-1:0]   m_line;
   logic                m_wr_en, m_wr_dirty;
   logic                main_hit;

   logic [VICTIMS-1:0]  vb_hit_vec;
   logic                vb_hit, vb_hit_dirty;
   logic [PTR_W-1:0]    vb_hit_idx, vb_ptr;
   logic [LINE_W-1:0]   vb_hit_line, vb_ptr_line;
   logic                vb_ptr_valid, vb_ptr_dirty;
   logic [LA_W-1:0]     vb_ptr_la;
   logic                vb_wr_en, vb_ptr_adv;
   logic [PTR_W-1:0]    vb_wr_idx;

   logic                acc_idle, fill_fire, rsp_fire, need_wb;
   logic [LINE_W-1:0]   src_line, new_line;
   logic [WORD_W-1:0]   rsp_word;
   logic                rsp_q;
   logic [WORD_W-1:0]   rdata_q;

   function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0]  off,
                                                   input logic [WORD_W-1:0] w);
      logic [LINE_W-1:0] r;
      r = line;
      r[int'(off)*WORD_W +: WORD_W] = w;
      return r;
   endfunction

   // address split: held request while a miss is in flight
   assign look_addr = (state_q == ST_IDLE) ? cpu_addr : q_addr;
   assign look_la   = look_addr[ADDR_W-1:OFF_W];
   assign look_off  = look_addr[OFF_W-1:0];
   assign look_idx  = look_la[IDX_W-1:0];
   assign look_tag  = look_la[LA_W-1:IDX_W];
   assign cur_we    = (state_q == ST_IDLE) ? cpu_we    : q_we;
   assign cur_wdata = (state_q == ST_IDLE) ? cpu_wdata : q_wdata;

   vc_main_array #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
   ) u_main (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(look_idx), .rd_valid(m_valid), .rd_dirty(m_dirty),
      .rd_tag(m_tag), .rd_line(m_line),
      .wr_en(m_wr_en), .wr_idx(look_idx), .wr_valid(1'b1),
      .wr_dirty(m_wr_dirty), .wr_tag(look_tag), .wr_line(new_line)
   );

   vc_victim_buf #(
      .NV(VICTIMS), .PTR_W(PTR_W), .LA_W(LA_W), .LINE_W(LINE_W)
   ) u_vb (
      .clk(clk), .rst_n(rst_n),
      .look_la(look_la), .hit_vec(vb_hit_vec), .hit(vb_hit),
      .hit_idx(vb_hit_idx), .hit_dirty(vb_hit_dirty), .hit_line(vb_hit_line),
      .ptr(vb_ptr), .ptr_valid(vb_ptr_valid), .ptr_dirty(vb_ptr_dirty),
      .ptr_la(vb_ptr_la), .ptr_line(vb_ptr_line),
      .wr_en(vb_wr_en), .wr_idx(vb_wr_idx), .wr_valid(m_valid),
      .wr_dirty(m_dirty), .wr_la({m_tag, look_idx}), .wr_line(m_line),
      .ptr_adv(vb_ptr_adv)
   );

   assign main_hit  = m_valid && (m_tag == look_tag);
   assign acc_idle  = (state_q == ST_IDLE) && cpu_req;
   assign fill_fire = (state_q == ST_FILL) && mem_fill_valid;
   assign need_wb   = m_valid && vb_ptr_valid && vb_ptr_dirty;

   // line that the access completes on, and its merged form
   always_comb begin
      case (state_q)
         ST_SWAP: src_line = vb_hit_line;
         ST_FILL: src_line = mem_fill_data;
         default: src_line = m_line;
      endcase
      new_line = cur_we ? put_word(src_line, look_off, cur_wdata) : src_line;
      rsp_word = new_line[int'(look_off)*WORD_W +: WORD_W];
   end

   assign m_wr_en    = (acc_idle && main_hit && cur_we) || (state_q == ST_SWAP) || fill_fire;
   assign m_wr_dirty = (state_q == ST_IDLE) ? 1'b1 :
                       (state_q == ST_SWAP) ? (vb_hit_dirty | cur_we) : cur_we;
   assign vb_wr_en   = (state_q == ST_SWAP) || (fill_fire && m_valid);
   assign vb_wr_idx  = (state_q == ST_SWAP) ? vb_hit_idx : vb_ptr;
   assign vb_ptr_adv = fill_fire && m_valid;
   assign rsp_fire   = (acc_idle && main_hit) || (state_q == ST_SWAP) || fill_fire;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (cpu_req && !main_hit) begin
               if (vb_hit)       state_d = ST_SWAP;
               else if (need_wb) state_d = ST_WB;
               else              state_d = ST_RDREQ;
            end
         end
         ST_SWAP:  state_d = ST_IDLE;
         ST_WB:    if (mem_wb_ready)   state_d = ST_RDREQ;
         ST_RDREQ: if (mem_rd_ready)   state_d = ST_FILL;
         ST_FILL:  if (mem_fill_valid) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rsp_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         rsp_q   <= rsp_fire;
      end
   end

   always_ff @(posedge clk) begin
      if (acc_idle) begin
         q_we    <= cpu_we;
         q_addr  <= cpu_addr;
         q_wdata <= cpu_wdata;
      end
      if (rsp_fire) rdata_q <= rsp_word;
   end

   assign cpu_ready      = (state_q == ST_IDLE);
   assign cpu_rsp_valid  = rsp_q;
   assign cpu_rdata      = rdata_q;
   assign mem_rd_valid   = (state_q == ST_RDREQ);
   assign mem_rd_addr    = q_addr[ADDR_W-1:OFF_W];
   assign mem_fill_ready = (state_q == ST_FILL);
   assign mem_wb_valid   = (state_q == ST_WB);
   assign mem_wb_addr    = vb_ptr_la;
   assign mem_wb_data    = vb_ptr_line;
endmodule

// File: rtl/vc_checker.sv
`timescale 1ns/1ps
module vc_checker #(
   parameter int LA_W = 8,
   parameter int NV   = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_req,
   input logic            cpu_ready,
   input logic            cpu_rsp_valid,
   input logic            mem_rd_valid,
   input logic            mem_rd_ready,
   input logic [LA_W-1:0] mem_rd_addr,
   input logic            mem_fill_valid,
   input logic            mem_fill_ready,
   input logic            mem_wb_valid,
   input logic            mem_wb_ready,
   input logic [LA_W-1:0] mem_wb_addr,
   input logic [NV-1:0]   vb_hit_vec,
   input logic            main_hit
);
   p_rsp_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |-> $past(!cpu_ready || cpu_req));

   p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

   p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_fill_valid && mem_fill_ready |=> cpu_rsp_valid && cpu_ready);

   p_one_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vb_hit_vec));

   p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      main_hit |-> !(|vb_hit_vec));

   p_swap_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && !main_hit && (|vb_hit_vec)
      |=> !cpu_ready && !mem_rd_valid && !mem_wb_valid);

   p_swap_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && !main_hit && (|vb_hit_vec) |-> ##2 cpu_rsp_valid);

   p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wb_valid && !mem_wb_ready |=> mem_wb_valid && $stable(mem_wb_addr));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_rd_valid && !mem_wb_valid && !mem_fill_ready);
endmodule

bind dm_victim_cache vc_checker #(.LA_W(LA_W), .NV(VICTIMS)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_req(cpu_req), .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid),
   .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
   .mem_fill_valid(mem_fill_valid), .mem_fill_ready(mem_fill_ready),
   .mem_wb_valid(mem_wb_valid), .mem_wb_ready(mem_wb_ready), .mem_wb_addr(mem_wb_addr),
   .vb_hit_vec(vb_hit_vec), .main_hit(main_hit)
);

// File: tb/sim_dm_victim_cache.sv
`timescale 1ns/1ps
module sim_dm_victim_cache;
   localparam int ADDR_W = 10, WORD_W = 32, LW = 4, SETS = 8, NV = 4;
   localparam int NWORDS = 1 << ADDR_W;
   localparam int LA_W = ADDR_W - 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [WORD_W-1:0] cpu_wdata = '0;
   logic cpu_ready, cpu_rsp_valid;
   logic [WORD_W-1:0] cpu_rdata;
   logic mem_rd_valid, mem_fill_ready, mem_wb_valid;
   logic mem_rd_ready = 1'b0, mem_fill_valid = 1'b0, mem_wb_ready = 1'b0;
   logic [LA_W-1:0] mem_rd_addr, mem_wb_addr;
   logic [WORD_W*LW-1:0] mem_fill_data = '0;
   logic [WORD_W*LW-1:0] mem_wb_data;

   logic [WORD_W-1:0] bmem    [NWORDS];
   logic [WORD_W-1:0] ref_mem [NWORDS];
   int rd_cnt = 0, wb_cnt = 0;
   logic [LA_W-1:0] last_rd_la, last_wb_la;
   logic [WORD_W*LW-1:0] last_wb_data;
   int vectors = 0, miscompares = 0;

   dm_victim_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LW),
                     .SETS(SETS), .VICTIMS(NV)) u0 (.*);

   initial forever #10 clk = ~clk;

   function automatic logic [WORD_W-1:0] init_word(input int i);
      return (i * 32'h9E3779B1) ^ 32'hC3A50F1E;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // memory model: grants, fills after a random delay, absorbs writebacks
   initial begin
      bit pend = 0;
      int cnt = 0;
      logic [LA_W-1:0] a = '0;
      forever begin
         @(negedge clk);
         if (mem_wb_valid && !mem_wb_ready) begin
            mem_wb_ready = 1'b1;
            for (int k = 0; k < LW; k++) bmem[int'(mem_wb_addr)*LW + k] = mem_wb_data[k*WORD_W +: WORD_W];
            last_wb_la = mem_wb_addr; last_wb_data = mem_wb_data; wb_cnt++;
         end else mem_wb_ready = 1'b0;
         if (pend) begin
            if (mem_fill_valid) begin mem_fill_valid = 1'b0; pend = 0; end
            else if (cnt == 0) begin
               for (int k = 0; k < LW; k++) mem_fill_data[k*WORD_W +: WORD_W] = bmem[int'(a)*LW + k];
               mem_fill_valid = 1'b1;
            end else cnt--;
         end
         if (mem_rd_valid && !mem_rd_ready && !pend) begin
            mem_rd_ready = 1'b1; pend = 1; a = mem_rd_addr; cnt = $urandom % 3;
            last_rd_la = mem_rd_addr; rd_cnt++;
         end else mem_rd_ready = 1'b0;
      end
   end

   task automatic access(input bit we, input int addr, input logic [WORD_W-1:0] wd,
                         output logic [WORD_W-1:0] rd, output int lat);
      @(negedge clk);
      while (!cpu_ready) @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      lat = 1;
      if (!cpu_rsp_valid) chk(!cpu_ready, "R10 busy during miss", cpu_ready, 0);
      while (!cpu_rsp_valid && lat < 200) begin @(negedge clk); lat++; end
      rd = cpu_rdata;
      if (we) ref_mem[addr] = wd;
   endtask

   task automatic rd_check(input int addr, input string req, output int lat);
      logic [WORD_W-1:0] r;
      access(0, addr, '0, r, lat);
      chk(r == ref_mem[addr], req, r, ref_mem[addr]);
   endtask

   initial begin
      logic [WORD_W-1:0] r;
      int lat, rd0, wb0;
      logic [WORD_W-1:0] X = 32'hDEADBEEF, Y = 32'h0BADF00D;
      for (int i = 0; i < NWORDS; i++) begin bmem[i] = init_word(i); ref_mem[i] = init_word(i); end
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      chk(cpu_ready && !cpu_rsp_valid && !mem_rd_valid && !mem_wb_valid, "R1 reset outputs",
          {cpu_ready, cpu_rsp_valid, mem_rd_valid, mem_wb_valid}, 4'b1000);
      rst_n = 1'b1;

      // R1/R4: cold miss on line 0
      rd0 = rd_cnt; rd_check(1, "R4 cold miss data", lat);
      chk(rd_cnt == rd0 + 1 && last_rd_la == 0, "R1 R4 fetch line 0", last_rd_la, 0);
      chk(lat >= 3, "R4 miss latency", lat, 3);
      // R2: hit
      rd0 = rd_cnt; rd_check(2, "R2 hit data", lat);
      chk(lat == 1 && rd_cnt == rd0, "R2 hit latency", lat, 1);
      // R3: write hit then read
      access(1, 3, X, r, lat);
      chk(lat == 1, "R3 write hit latency", lat, 1);
      rd_check(3, "R3 read after write", lat);
      // R5: conflict displaces line 0 into victim buffer
      rd0 = rd_cnt; rd_check(33, "R5 conflict fill", lat);
      chk(rd_cnt == rd0 + 1 && last_rd_la == 8, "R5 conflict fetch", last_rd_la, 8);
      // R6: victim hit swap, both directions
      rd0 = rd_cnt; wb0 = wb_cnt; rd_check(3, "R6 victim hit data", lat);
      chk(lat == 2 && rd_cnt == rd0 && wb_cnt == wb0, "R5 R6 victim hit latency", lat, 2);
      rd_check(33, "R6 swapped line data", lat);
      chk(lat == 2 && rd_cnt == rd0, "R6 displaced line in victim", lat, 2);
      // R7/R8: FIFO through set 0, dirty line 0 leaves
      wb0 = wb_cnt;
      rd_check(64, "R7 chain fill", lat);
      rd_check(96, "R7 chain fill", lat);
      rd_check(128, "R7 chain fill", lat);
      chk(wb_cnt == wb0, "R8 no writeback of empty slots", wb_cnt, wb0);
      rd_check(160, "R8 fill after writeback", lat);
      chk(wb_cnt == wb0 + 1 && last_wb_la == 0, "R8 dirty victim written back", last_wb_la, 0);
      chk(last_wb_data[3*WORD_W +: WORD_W] == X, "R8 writeback data", last_wb_data[3*WORD_W +: WORD_W], X);
      rd0 = rd_cnt; wb0 = wb_cnt; rd_check(3, "R7 oldest victim refetched", lat);
      chk(rd_cnt == rd0 + 1 && last_rd_la == 0, "R7 FIFO evicted oldest", last_rd_la, 0);
      chk(wb_cnt == wb0, "R8 clean victim not written back", wb_cnt, wb0);
      // R9: write miss allocate and merge
      rd0 = rd_cnt; access(1, 402, Y, r, lat);
      chk(rd_cnt == rd0 + 1 && last_rd_la == 100 && lat >= 3, "R9 write miss fetch", last_rd_la, 100);
      rd_check(402, "R9 merged word", lat);
      chk(lat == 1, "R9 line resident", lat, 1);
      rd_check(400, "R9 untouched word", lat);

      // random mix over hot sets and the full space
      for (int n = 0; n < 3000; n++) begin
         int line, addr;
         bit we;
         if ($urandom % 2) line = ($urandom % 6) * SETS + ($urandom % 2);
         else              line = $urandom % (NWORDS / LW);
         addr = line * LW + ($urandom % LW);
         we = ($urandom % 10) < 4;
         if (we) access(1, addr, $urandom, r, lat);
         else    rd_check(addr, "R6 R8 random read data", lat);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R10 watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule